// File: doc/BRIEF.md
# Masked Data Watchpoint Unit

This unit watches the data accesses of a processor pipeline and raises a break indication when an access falls inside a programmed window. It holds N independent watch channels. Each channel has a 32-bit address register and a 32-bit control word. The control word selects whether the channel watches loads, stores or both. It also carries a 6-bit field that picks which of the lowest address bits take part in the comparison.

Every access presents an address, a write flag and a valid strobe. One clock later the unit reports whether any channel matched and which channel that was. The debug entry logic uses this result to stop the access before it commits. The 6-bit field must describe a window that is aligned to a power of two. If software writes a field with gaps in it, the unit keeps only the unbroken run of ones that starts at the top bit of the field. It also sets a sticky per-channel flag, which software can clear.

Top module: `dbk_unit`

## Requirements
- R1: During and after a synchronous reset `brk_hit` is 0, `brk_ch` is 0 and `mask_flag` is all zeros. Every channel then has both enable bits clear and its address and mask cleared.
- R2: A write access (`acc_write`=1) can match a channel only while control bit 31 (store enable) of that channel is 1.
- R3: A read access (`acc_write`=0) can match a channel only while control bit 30 (load enable) of that channel is 1.
- R4: A channel whose control bits 31 and 30 are both 0 never matches, whatever the address.
- R5: Control bits 5:0 form the mask field. A 1 in bit k (k<6) makes address bit k part of the comparison, and a 0 leaves it out. Address bits 31:6 are always compared. A match requires equality on every compared bit.
- R6: When a control word is written, the mask field is normalised. Counting from bit 5 downward, the bits up to the first 0 are kept, and that bit and every bit below it become 0 (for example 110101 is stored as 110000).
- R7: A control write whose mask field changes under R6 sets `mask_flag[ch]`. The flag stays set until `flag_clr` is pulsed. If a clear and such a write fall in the same cycle, the flag ends up set.
- R8: When several channels match the same access, `brk_ch` reports the lowest-numbered one.
- R9: `brk_hit` and `brk_ch` are registered and appear on the clock edge after the edge that samples the access. They use the register contents from before that edge, so a register write in the same cycle as an access does not affect that access.
- R10: With `acc_valid` at 0, `brk_hit` is 0 on the following cycle. Whenever `brk_hit` is 0, `brk_ch` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_ch | input | CW | Channel selected by the write |
| reg_sel_ctl | input | 1 | 1 writes the control word, 0 writes the address |
| reg_wdata | input | 32 | Write data |
| flag_clr | input | 1 | Clears every mask flag |
| acc_valid | input | 1 | Access strobe |
| acc_write | input | 1 | 1 for a store, 0 for a load |
| acc_addr | input | AW | Access address |
| brk_hit | output | 1 | Registered break indication |
| brk_ch | output | CW | Registered index of the matching channel |
| mask_flag | output | N | Sticky flag per channel: a gapped mask was written |

## Verification
Break results are due exactly one clock after the edge that samples the access, and the mask flags change on the edge that takes the control write. The bench's reference model advances on the same rising edge as the design and uses the inputs held during the preceding cycle. The outputs are compared against it at every falling edge, so each comparison sees a settled, one-register-delayed value. The stimulus includes a register write in the same cycle as an access and a flag clear in the same cycle as a flagged write, which fixes the ordering rules of R7 and R9.

// File: rtl/dbk_pkg.sv
package dbk_pkg;
  localparam int unsigned CTL_W   = 32;
  localparam int unsigned FIELD_W = 6;
  localparam int unsigned ST_BIT  = 31;
  localparam int unsigned LD_BIT  = 30;
endpackage

// File: rtl/dbk_mask_norm.sv
module dbk_mask_norm #(
  parameter int unsigned MW = 6
) (
  input  logic [MW-1:0] raw,
  output logic [MW-1:0] trimmed,
  output logic          gapped
);
  for (genvar g = 0; g < MW; g++) begin : g_run
    assign trimmed[g] = &raw[MW-1:g];
  end
  assign gapped = (trimmed != raw);
endmodule

// File: rtl/dbk_channel.sv
module dbk_channel
  import dbk_pkg::*;
#(
  parameter int unsigned AW  = 32,
  parameter int unsigned CW  = 2,
  parameter int unsigned IDX = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_we,
  input  logic [CW-1:0]    reg_ch,
  input  logic             reg_sel_ctl,
  input  logic [CTL_W-1:0] reg_wdata,
  input  logic             flag_clr,
  input  logic             acc_valid,
  input  logic             acc_write,
  input  logic [AW-1:0]    acc_addr,
  output logic             match,
  output logic             flag
);
  localparam int unsigned MW = FIELD_W;

  logic [AW-1:0] addr_q;
  logic          st_q, ld_q, flag_q;
  logic [MW-1:0] msk_q, msk_n, msk_inv;
  logic          gap;
  logic          sel;
  logic [AW-1:0] cmp_mask;

  dbk_mask_norm #(.MW(MW)) u_norm (
    .raw    (reg_wdata[MW-1:0]),
    .trimmed(msk_n),
    .gapped (gap)
  );

  assign sel = reg_we && (reg_ch == CW'(IDX));

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      st_q   <= 1'b0;
      ld_q   <= 1'b0;
      msk_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (sel && !reg_sel_ctl) addr_q <= reg_wdata[AW-1:0];
      if (sel && reg_sel_ctl) begin
        st_q  <= reg_wdata[ST_BIT];
        ld_q  <= reg_wdata[LD_BIT];
        msk_q <= msk_n;
      end
      flag_q <= (flag_q && !flag_clr) || (sel && reg_sel_ctl && gap);
    end
  end

  assign cmp_mask = {{(AW-MW){1'b1}}, msk_q};
  assign match = acc_valid && (acc_write ? st_q : ld_q) &&
                 (((acc_addr ^ addr_q) & cmp_mask) == '0);
  assign flag = flag_q;

  // stored mask is always a solid run of ones from the top of the field
  assign msk_inv = ~msk_q;
  p_mask_solid_r6: assert property (@(posedge clk) disable iff (rst)
    (msk_inv & (msk_inv + 1'b1)) == '0);

  p_flag_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !flag_clr) |=> flag_q);
endmodule

// File: rtl/dbk_pick.sv
module dbk_pick #(
  parameter int unsigned N  = 4,
  parameter int unsigned CW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  hit_vec,
  output logic          brk_hit,
  output logic [CW-1:0] brk_ch
);
  logic [CW-1:0] low_idx;

  always_comb begin
    low_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit_vec[i]) low_idx = CW'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      brk_hit <= 1'b0;
      brk_ch  <= '0;
    end else begin
      brk_hit <= |hit_vec;
      brk_ch  <= (|hit_vec) ? low_idx : '0;
    end
  end

  p_lowest_wins_r8: assert property (@(posedge clk) disable iff (rst)
    brk_hit |-> ((($past(hit_vec) >> brk_ch) & N'(1)) == N'(1)) &&
                (($past(hit_vec) & ((N'(1) << brk_ch) - N'(1))) == '0));
endmodule

// File: rtl/dbk_unit.sv
module dbk_unit
  import dbk_pkg::*;
#(
  parameter int unsigned N  = 4,
  parameter int unsigned AW = 32,
  localparam int unsigned CW = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_we,
  input  logic [CW-1:0]    reg_ch,
  input  logic             reg_sel_ctl,
  input  logic [CTL_W-1:0] reg_wdata,
  input  logic             flag_clr,
  input  logic             acc_valid,
  input  logic             acc_write,
  input  logic [AW-1:0]    acc_addr,
  output logic             brk_hit,
  output logic [CW-1:0]    brk_ch,
  output logic [N-1:0]     mask_flag
);
  logic [N-1:0] hit_vec;

  for (genvar c = 0; c < N; c++) begin : g_ch
    dbk_channel #(.AW(AW), .CW(CW), .IDX(c)) u_ch (
      .clk        (clk),
      .rst        (rst),
      .reg_we     (reg_we),
      .reg_ch     (reg_ch),
      .reg_sel_ctl(reg_sel_ctl),
      .reg_wdata  (reg_wdata),
      .flag_clr   (flag_clr),
      .acc_valid  (acc_valid),
      .acc_write  (acc_write),
      .acc_addr   (acc_addr),
      .match      (hit_vec[c]),
      .flag       (mask_flag[c])
    );
  end

  dbk_pick #(.N(N), .CW(CW)) u_pick (
    .clk    (clk),
    .rst    (rst),
    .hit_vec(hit_vec),
    .brk_hit(brk_hit),
    .brk_ch (brk_ch)
  );

  p_hit_needs_access_r10: assert property (@(posedge clk) disable iff (rst)
    brk_hit |-> $past(acc_valid));
endmodule

// File: tb/dbk_unit_tb.sv
module dbk_unit_tb;
  localparam int N  = 4;
  localparam int CW = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          reg_we = 1'b0;
  logic [CW-1:0] reg_ch = '0;
  logic          reg_sel_ctl = 1'b0;
  logic [31:0]   reg_wdata = '0;
  logic          flag_clr = 1'b0;
  logic          acc_valid = 1'b0;
  logic          acc_write = 1'b0;
  logic [31:0]   acc_addr = '0;
  logic          brk_hit;
  logic [CW-1:0] brk_ch;
  logic [N-1:0]  mask_flag;

  always #4 clk = ~clk;

  dbk_unit #(.N(N), .AW(32)) u_dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_ch(reg_ch),
    .reg_sel_ctl(reg_sel_ctl), .reg_wdata(reg_wdata), .flag_clr(flag_clr),
    .acc_valid(acc_valid), .acc_write(acc_write), .acc_addr(acc_addr),
    .brk_hit(brk_hit), .brk_ch(brk_ch), .mask_flag(mask_flag)
  );

  int vectors = 0;
  int errors = 0;
  string cur_req = "R1";
  bit armed = 0;
  bit done = 0;

  // behavioural reference state
  logic [31:0] m_addr [N];
  bit          m_st [N];
  bit          m_ld [N];
  logic [5:0]  m_msk [N];
  logic [N-1:0] m_flag;
  bit          e_hit;
  int          e_ch;

  function automatic logic [5:0] trim(input logic [5:0] f);
    int n = 0;
    while (n < 6 && f[5 - n]) n++;
    return 6'((63 << (6 - n)) & 63);
  endfunction

  always @(posedge clk) begin
    bit h;
    int c;
    armed = 1;
    if (rst) begin
      for (int i = 0; i < N; i++) begin
        m_addr[i] = '0; m_st[i] = 0; m_ld[i] = 0; m_msk[i] = '0;
      end
      m_flag = '0; e_hit = 0; e_ch = 0;
    end else begin
      h = 0; c = 0;
      for (int i = N - 1; i >= 0; i--) begin
        logic [31:0] fm;
        fm = {26'h3ffffff, m_msk[i]};
        if (acc_valid && (acc_write ? m_st[i] : m_ld[i]) &&
            ((acc_addr & fm) == (m_addr[i] & fm))) begin
          h = 1; c = i;
        end
      end
      e_hit = h; e_ch = c;
      if (flag_clr) m_flag = '0;
      if (reg_we) begin
        if (reg_sel_ctl) begin
          m_st[reg_ch] = reg_wdata[31];
          m_ld[reg_ch] = reg_wdata[30];
          m_msk[reg_ch] = trim(reg_wdata[5:0]);
          if (trim(reg_wdata[5:0]) != reg_wdata[5:0]) m_flag[reg_ch] = 1'b1;
        end else begin
          m_addr[reg_ch] = reg_wdata;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (armed && !done) begin
      vectors++;
      if (brk_hit !== e_hit || brk_ch !== CW'(e_ch) || mask_flag !== m_flag) begin
        errors++;
        $display("FAIL %s: hit=%0b ch=%0d flags=%b, expected hit=%0b ch=%0d flags=%b",
                 cur_req, brk_hit, brk_ch, mask_flag, e_hit, e_ch, m_flag);
      end
    end
  end

  task automatic cyc(input bit we, input int ch, input bit ctl, input logic [31:0] d,
                     input bit clr, input bit av, input bit aw, input logic [31:0] aa);
    @(negedge clk);
    reg_we = we; reg_ch = CW'(ch); reg_sel_ctl = ctl; reg_wdata = d;
    flag_clr = clr; acc_valid = av; acc_write = aw; acc_addr = aa;
  endtask

  task automatic wr(input int ch, input bit ctl, input logic [31:0] d);
    cyc(1, ch, ctl, d, 0, 0, 0, '0);
  endtask

  task automatic acc(input logic [31:0] a, input bit w);
    cyc(0, 0, 0, '0, 0, 1, w, a);
  endtask

  task automatic idle();
    cyc(0, 0, 0, '0, 0, 0, 0, '0);
  endtask

  initial begin
    cur_req = "R1";
    repeat (3) @(negedge clk);
    rst = 1'b0;
    acc(32'h0, 0); acc(32'h0, 1); idle();

    cur_req = "R2";
    wr(0, 0, 32'h1000_0040); wr(0, 1, 32'h8000_003f);
    acc(32'h1000_0040, 1); idle();
    cur_req = "R3";
    acc(32'h1000_0040, 0); idle();
    cur_req = "R5";
    acc(32'h1000_0041, 1); acc(32'h1000_0140, 1); idle();

    cur_req = "R5";
    wr(1, 0, 32'h2000_0000); wr(1, 1, 32'h4000_0038);
    acc(32'h2000_0005, 0); acc(32'h2000_0008, 0); acc(32'h2000_0040, 0);
    cur_req = "R2";
    acc(32'h2000_0000, 1); idle();

    cur_req = "R6";
    wr(2, 0, 32'h3000_0000); wr(2, 1, 32'hC000_0035);
    acc(32'h3000_0004, 0); acc(32'h3000_000b, 1); acc(32'h3000_0010, 0); idle();

    cur_req = "R7";
    repeat (3) idle();
    cyc(0, 0, 0, '0, 1, 0, 0, '0); idle();
    cyc(1, 2, 1, 32'hC000_0035, 1, 0, 0, '0); idle();
    cyc(1, 1, 1, 32'h4000_003c, 1, 0, 0, '0); idle();
    wr(3, 1, 32'h0000_0001); idle();

    cur_req = "R4";
    wr(3, 0, 32'h2000_0000); wr(3, 1, 32'h0000_0000);
    acc(32'h2000_0000, 0); acc(32'h2000_0000, 1); idle();

    cur_req = "R8";
    wr(1, 1, 32'h4000_0038); wr(3, 1, 32'hC000_0000);
    acc(32'h2000_0001, 0);
    wr(0, 0, 32'h2000_0000); wr(0, 1, 32'h4000_0000);
    acc(32'h2000_0002, 0); acc(32'h2000_0002, 1); idle();

    cur_req = "R9";
    cyc(1, 0, 0, 32'h5000_0000, 0, 1, 0, 32'h2000_0000);
    acc(32'h2000_0000, 0); acc(32'h5000_0000, 0);
    cyc(1, 0, 1, 32'h0000_0000, 0, 1, 0, 32'h5000_0000);
    acc(32'h5000_0000, 0); idle();

    cur_req = "R10";
    cyc(0, 0, 0, '0, 0, 0, 0, 32'h2000_0000);
    cyc(0, 0, 0, '0, 0, 0, 1, 32'h2000_0000); idle();

    cur_req = "R1";
    @(negedge clk); rst = 1'b1;
    acc(32'h2000_0000, 0);
    @(negedge clk); rst = 1'b0;
    acc(32'h2000_0000, 0); acc(32'h2000_0000, 1); idle(); idle();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule